// File: doc/BRIEF.md
# Four-Channel Timer Compare Unit with PWM and Shadow Outputs

This block pairs a free-running up-counter with four compare channels. Each channel holds a 16-bit threshold and owns one output pin and one interrupt line. A channel that is enabled for compare takes its pin away from the plain port register. One global mode bit then picks what a compare event does to the pin. In pulse-width mode the event sets the pin and the next timer wrap clears it. In shadow mode the event copies the channel's port bit to the pin, so a port write only reaches the pin on a match.

A byte-mode control narrows both the counter and the comparison to the low eight bits. This gives a PWM period of 256 cycles. Software programs the block through a single-cycle write port. There is no read path. The timer value, the overflow pulse and the compare events are brought out directly.

The compare condition is evaluated on the registered timer value. A threshold C therefore gives its event in the cycle in which the timer output reads C+2. The pin and the interrupt change in that same cycle.

Top module: `tcmp_pwm`

## Requirements
- R1: The timer counts up by one every cycle and wraps from 0xFFFF to 0. In byte mode (address 0, bit 0 = 1) the high byte reads 0 and the count wraps from 0xFF to 0. A write to address 4 loads the timer (only the low byte in byte mode).
- R2: `ovf_o` is high for exactly one cycle, the cycle in which the timer reads 0 after a counting wrap. A load never raises it.
- R3: A channel's compare condition is "timer greater than threshold", taken over 16 bits. In byte mode only the low bytes are compared. The threshold of channel k is written at address 8+k.
- R4: `cmp_evt_o[k]` is a one-cycle pulse. It appears in the cycle after the first cycle in which the timer value satisfies the condition, and only if channel k is compare-enabled (address 1, bit k).
- R5: In pulse-width mode (address 0, bit 1 = 0), an enabled channel's pin goes to 1 on its event and to 0 on each timer wrap. A wrap wins over a simultaneous event.
- R6: In shadow mode (address 0, bit 1 = 1), an enabled channel's pin takes port bit k (address 2, bit k) on its event. A port write alone and a timer wrap leave the pin unchanged.
- R7: In both modes the pin takes its new value in the same cycle in which `cmp_evt_o[k]` is high.
- R8: `irq_o[k]` is set by an event of channel k when its interrupt enable (address 1, bit 8+k) is 1. It stays set until a write of 1 to bit k at address 3. A set wins over a clear in the same cycle.
- R9: A channel that is not compare-enabled drives port bit k onto its pin, starting in the cycle after the port write.
- R10: After reset the timer, pins, interrupts, events, overflow and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | TMR_W | Register write data |
| pin_o | output | NUM_CH | Channel output pins |
| irq_o | output | NUM_CH | Sticky per-channel interrupt requests |
| cmp_evt_o | output | NUM_CH | One-cycle compare event per channel |
| ovf_o | output | 1 | One-cycle timer overflow pulse |
| tmr_o | output | TMR_W | Current timer value |

## Verification
The assertions that tie pins to events and overflows assume the mode and enable registers did not change at the previous clock edge. A property that sees a write at that edge excuses itself. The stimulus applies configuration writes as isolated single-cycle strobes, with long runs of free counting between them. Most of the checked behaviour therefore happens under a steady configuration. The sweeps choose thresholds across the whole low-byte range, including 0xFF, which never fires in byte mode. They also load the timer close to its 16-bit wrap, so that every period completes within the run.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int REG_CTRL     = 0;
  localparam int REG_CHEN     = 1;
  localparam int REG_PORT     = 2;
  localparam int REG_IRQCLR   = 3;
  localparam int REG_TLOAD    = 4;
  localparam int REG_CMP_BASE = 8;
  localparam int IE_LSB       = 8;
  localparam int LO_W         = 8;

  typedef struct packed {
    logic shadow_mode;
    logic byte_mode;
  } ctrl_t;
endpackage

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
  parameter int TMR_W = 16,
  parameter int LO_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_mode_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  localparam int HI_W = TMR_W - LO_W;

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             ovf_q;

  always_comb begin
    wrap_o = !load_i && (byte_mode_i ? (&tmr_q[LO_W-1:0]) : (&tmr_q));
    if (load_i)
      tmr_d = byte_mode_i ? {{HI_W{1'b0}}, load_val_i[LO_W-1:0]} : load_val_i;
    else if (byte_mode_i)
      tmr_d = {{HI_W{1'b0}}, tmr_q[LO_W-1:0] + LO_W'(1)};
    else
      tmr_d = tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      ovf_q <= wrap_o;
    end
  end

  assign tmr_o = tmr_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tcmp_regs.sv
module tcmp_regs
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  output logic              byte_mode_o,
  output logic              shadow_mode_o,
  output logic [NUM_CH-1:0] ce_o,
  output logic [NUM_CH-1:0] ie_o,
  output logic [NUM_CH-1:0] port_o,
  output logic [TMR_W-1:0]  cmp_o [NUM_CH],
  output logic [NUM_CH-1:0] irq_clr_o,
  output logic              tload_o,
  output logic [TMR_W-1:0]  tload_val_o
);
  ctrl_t             ctrl_q;
  logic [NUM_CH-1:0] ce_q, ie_q, port_q;

  logic sel_ctrl, sel_chen, sel_port, sel_clr;
  assign sel_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
  assign sel_chen = wr_en_i && (wr_addr_i == ADDR_W'(REG_CHEN));
  assign sel_port = wr_en_i && (wr_addr_i == ADDR_W'(REG_PORT));
  assign sel_clr  = wr_en_i && (wr_addr_i == ADDR_W'(REG_IRQCLR));
  assign tload_o  = wr_en_i && (wr_addr_i == ADDR_W'(REG_TLOAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ce_q   <= '0;
      ie_q   <= '0;
      port_q <= '0;
    end else begin
      if (sel_ctrl) ctrl_q <= ctrl_t'(wr_data_i[1:0]);
      if (sel_chen) begin
        ce_q <= wr_data_i[NUM_CH-1:0];
        ie_q <= wr_data_i[IE_LSB+NUM_CH-1:IE_LSB];
      end
      if (sel_port) port_q <= wr_data_i[NUM_CH-1:0];
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
    logic [TMR_W-1:0] cmp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(REG_CMP_BASE + k))) cmp_q <= wr_data_i;
    end
    assign cmp_o[k] = cmp_q;
  end

  assign byte_mode_o   = ctrl_q.byte_mode;
  assign shadow_mode_o = ctrl_q.shadow_mode;
  assign ce_o          = ce_q;
  assign ie_o          = ie_q;
  assign port_o        = port_q;
  assign irq_clr_o     = sel_clr ? wr_data_i[NUM_CH-1:0] : '0;
  assign tload_val_o   = wr_data_i;
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int TMR_W = 16,
  parameter int LO_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic             wrap_i,
  input  logic [TMR_W-1:0] cmp_i,
  input  logic             byte_mode_i,
  input  logic             shadow_mode_i,
  input  logic             ce_i,
  input  logic             ie_i,
  input  logic             port_i,
  input  logic             irq_clr_i,
  output logic             pin_o,
  output logic             irq_o,
  output logic             evt_o
);
  logic cond_c, cond_q, rise_c;
  logic out_q, irq_q, evt_q;

  always_comb begin
    cond_c = byte_mode_i ? (tmr_i[LO_W-1:0] > cmp_i[LO_W-1:0]) : (tmr_i > cmp_i);
    // edge, not level: one event per crossing
    rise_c = ce_i && cond_c && !cond_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      evt_q  <= 1'b0;
      out_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond_c;
      evt_q  <= rise_c;
      if (!shadow_mode_i && wrap_i) out_q <= 1'b0;
      else if (rise_c)              out_q <= shadow_mode_i ? port_i : 1'b1;
      irq_q <= (irq_q && !irq_clr_i) || (rise_c && ie_i);
    end
  end

  assign pin_o = ce_i ? out_q : port_i;
  assign irq_o = irq_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/tcmp_pwm.sv
module tcmp_pwm
  import tcmp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TMR_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0] pin_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] cmp_evt_o,
  output logic              ovf_o,
  output logic [TMR_W-1:0]  tmr_o
);
  logic              byte_mode, shadow_mode, tload, wrap;
  logic [NUM_CH-1:0] ce, ie, port, irq_clr;
  logic [TMR_W-1:0]  cmp [NUM_CH];
  logic [TMR_W-1:0]  tload_val, tmr;

  tcmp_regs #(.NUM_CH(NUM_CH), .TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .byte_mode_o(byte_mode), .shadow_mode_o(shadow_mode),
    .ce_o(ce), .ie_o(ie), .port_o(port), .cmp_o(cmp),
    .irq_clr_o(irq_clr), .tload_o(tload), .tload_val_o(tload_val)
  );

  tcmp_timer #(.TMR_W(TMR_W), .LO_W(LO_W)) u_timer (
    .clk_i, .rst_ni, .byte_mode_i(byte_mode), .load_i(tload),
    .load_val_i(tload_val), .tmr_o(tmr), .wrap_o(wrap), .ovf_o(ovf_o)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    tcmp_channel #(.TMR_W(TMR_W), .LO_W(LO_W)) u_ch (
      .clk_i, .rst_ni, .tmr_i(tmr), .wrap_i(wrap), .cmp_i(cmp[k]),
      .byte_mode_i(byte_mode), .shadow_mode_i(shadow_mode),
      .ce_i(ce[k]), .ie_i(ie[k]), .port_i(port[k]), .irq_clr_i(irq_clr[k]),
      .pin_o(pin_o[k]), .irq_o(irq_o[k]), .evt_o(cmp_evt_o[k])
    );
  end

  assign tmr_o = tmr;
endmodule

// File: rtl/tcmp_pwm_chk.sv
module tcmp_pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int TMR_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [NUM_CH-1:0] pin_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] cmp_evt_o,
  input logic              ovf_o,
  input logic [TMR_W-1:0]  tmr_o,
  input logic              shadow_mode_i,
  input logic [NUM_CH-1:0] ce_i,
  input logic [NUM_CH-1:0] irq_clr_i
);
  assert_ovf_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> tmr_o == '0);
  assert_ovf_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_a
    assert_evt_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_evt_o[k] |=> !cmp_evt_o[k]);
    assert_evt_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_evt_o[k] && !$past(wr_en_i) |-> ce_i[k]);
    assert_pwm_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_evt_o[k] && !shadow_mode_i && !ovf_o && !$past(wr_en_i) |-> pin_o[k]);
    assert_pwm_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o && !shadow_mode_i && ce_i[k] && !$past(wr_en_i) |-> !pin_o[k]);
    assert_shadow_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shadow_mode_i && ce_i[k] && !cmp_evt_o[k] && !$past(wr_en_i) |-> $stable(pin_o[k]));
    assert_port_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce_i[k] && !$past(wr_en_i) |-> $stable(pin_o[k]));
    assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[k]) |-> cmp_evt_o[k]);
    assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[k] && !irq_clr_i[k] |=> irq_o[k]);
  end
endmodule

bind tcmp_pwm tcmp_pwm_chk #(.NUM_CH(NUM_CH), .TMR_W(TMR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .pin_o(pin_o),
  .irq_o(irq_o), .cmp_evt_o(cmp_evt_o), .ovf_o(ovf_o), .tmr_o(tmr_o),
  .shadow_mode_i(shadow_mode), .ce_i(ce), .irq_clr_i(irq_clr)
);

// File: tb/tcmp_pwm_bench.sv
module tcmp_pwm_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pin, irq, evt;
  logic        ovf;
  logic [15:0] tmr;

  int total = 0;
  int bad = 0;
  logic chk_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcmp_pwm u_tcmp_pwm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pin_o(pin), .irq_o(irq), .cmp_evt_o(evt),
    .ovf_o(ovf), .tmr_o(tmr)
  );

  // requirement-level model
  logic [15:0] m_tmr, m_cmp [4];
  logic        m_ovf, m_byte, m_shadow;
  logic [3:0]  m_ce, m_ie, m_port, m_cond, m_out, m_irq, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = '0; m_ovf = 0; m_byte = 0; m_shadow = 0;
      m_ce = '0; m_ie = '0; m_port = '0; m_cond = '0; m_out = '0; m_irq = '0; m_evt = '0;
      for (int k = 0; k < 4; k++) m_cmp[k] = '0;
    end else begin
      logic ld, wr;
      logic c, r;
      ld = wr_en && wr_addr == 4'd4;
      wr = !ld && (m_byte ? (m_tmr[7:0] == 8'hFF) : (m_tmr == 16'hFFFF));
      for (int k = 0; k < 4; k++) begin
        c = m_byte ? (m_tmr[7:0] > m_cmp[k][7:0]) : (m_tmr > m_cmp[k]);
        r = m_ce[k] && c && !m_cond[k];
        m_cond[k] = c;
        m_evt[k] = r;
        if (!m_shadow && wr) m_out[k] = 1'b0;
        else if (r) m_out[k] = m_shadow ? m_port[k] : 1'b1;
        m_irq[k] = (m_irq[k] && !(wr_en && wr_addr == 4'd3 && wr_data[k])) || (r && m_ie[k]);
      end
      m_ovf = wr;
      if (ld) m_tmr = m_byte ? {8'h00, wr_data[7:0]} : wr_data;
      else if (m_byte) m_tmr = {8'h00, m_tmr[7:0] + 8'd1};
      else m_tmr = m_tmr + 16'd1;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_byte = wr_data[0]; m_shadow = wr_data[1]; end
          4'd1: begin m_ce = wr_data[3:0]; m_ie = wr_data[11:8]; end
          4'd2: m_port = wr_data[3:0];
          4'd8, 4'd9, 4'd10, 4'd11: m_cmp[wr_addr - 4'd8] = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 timer", 32'(tmr), 32'(m_tmr));
      chk("R2 overflow", 32'(ovf), 32'(m_ovf));
      for (int k = 0; k < 4; k++) begin
        chk("R4 event", 32'(evt[k]), 32'(m_evt[k]));
        chk("R8 irq", 32'(irq[k]), 32'(m_irq[k]));
        if (!m_ce[k])      chk("R9 port pin", 32'(pin[k]), 32'(m_port[k]));
        else if (m_shadow) chk("R6 shadow pin", 32'(pin[k]), 32'(m_out[k]));
        else               chk("R5 pwm pin", 32'(pin[k]), 32'(m_out[k]));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tmr(input logic [15:0] v);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tmr !== v && n < 70000);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pins", 32'(pin), 0);
    chk("R10 irq", 32'(irq), 0);
    chk("R10 evt", 32'(evt), 0);
    chk("R10 ovf", 32'(ovf), 0);
    chk("R10 timer", 32'(tmr), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R9: disabled channels follow port register
    wr(4'd2, 16'h000A);
    chk("R9 port to pin", 32'(pin), 32'hA);

    // R3/R4/R7: byte mode, high byte of threshold ignored
    wr(4'd2, 16'h0000);
    wr(4'd0, 16'h0001);
    wr(4'd8, 16'h1240);
    wr(4'd1, 16'h0101);
    wr(4'd4, 16'h0000);
    wait_tmr(16'h0041);
    chk("R4 no event at C+1", 32'(evt[0]), 0);
    @(negedge clk);
    chk("R3 byte compare event", 32'(evt[0]), 1);
    chk("R7 pin with event", 32'(pin[0]), 1);
    chk("R8 irq set", 32'(irq[0]), 1);
    wait_tmr(16'h0000);
    chk("R2 ovf at zero", 32'(ovf), 1);
    chk("R5 pwm cleared", 32'(pin[0]), 0);
    chk("R8 irq sticky", 32'(irq[0]), 1);
    wr(4'd3, 16'h0001);
    chk("R8 irq cleared", 32'(irq[0]), 0);

    // R6: shadow mode
    wr(4'd0, 16'h0003);
    wr(4'd8, 16'h0080);
    wr(4'd4, 16'h0000);
    wr(4'd2, 16'h0001);
    chk("R6 port write held", 32'(pin[0]), 0);
    wait_tmr(16'h0082);
    chk("R6 shadow to pin", 32'(pin[0]), 1);
    chk("R7 shadow with event", 32'(evt[0]), 1);
    wr(4'd2, 16'h0000);
    chk("R6 pin kept", 32'(pin[0]), 1);
    wait_tmr(16'h0000);
    chk("R6 overflow ignored", 32'(pin[0]), 1);

    // sweep: byte mode, pulse-width
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0F0F);
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 4; k++)
        wr(4'(8 + k), 16'((s << 8) | ((s * 16 + k * 5) & 8'hFF)));
      wr(4'd3, 16'h000F);
      repeat (260) @(negedge clk);
    end

    // sweep: byte mode, shadow
    wr(4'd0, 16'h0003);
    wr(4'd1, 16'h0A0F);
    for (int s = 0; s < 16; s++) begin
      wr(4'd2, 16'(s));
      for (int k = 0; k < 4; k++)
        wr(4'(8 + k), 16'(((15 - s) * 16 + k * 3) & 8'hFF));
      repeat (260) @(negedge clk);
    end

    // sweep: 16-bit, pulse-width near top of range
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h050F);
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++)
        wr(4'(8 + k), 16'(16'hFF00 + s * 60 + k * 7));
      wr(4'd4, 16'hFF00);
      repeat (270) @(negedge clk);
      wr(4'd3, 16'h000F);
    end

    // partial enable: mixed port and compare pins
    wr(4'd1, 16'h0003);
    wr(4'd2, 16'h000C);
    repeat (5) @(negedge clk);
    chk("R9 mixed port pins", 32'(pin[3:2]), 32'h3);

    chk_on = 1'b0;
    summary();
  end
endmodule